// File: doc/BRIEF.md
# Inhibitable Cycle Counter with Overflow Flag

This block is the cycle counter of an I/O translation unit's performance monitor. It counts clock cycles in a 63-bit field and keeps a sticky overflow flag in bit 63 of the same 64-bit register. Software can load a new count at any time. An inhibit control bit freezes the count, and clearing that bit lets counting go on from the held value.

When the count wraps from its all-ones value to zero and the overflow summary bit is clear, the block sets both the register's flag and the summary bit and pulses the performance-monitor interrupt request for one cycle. When the summary bit is already set at wrap time, no new request is made. A counter write with bit 63 clear clears the flag and the summary bit. A separate clear input also returns the summary bit to zero.

Two small state machines do the control. The inhibit machine has the states `CTL_RUN` and `CTL_HOLD`. Its transitions are *freeze*, taken on an inhibit write of 1 in `CTL_RUN`, and *resume*, taken on an inhibit write of 0 in `CTL_HOLD`. The summary machine has the states `SUM_IDLE` and `SUM_SET`. Its transitions are *first overflow*, taken on a wrap in `SUM_IDLE`, and *acknowledge*, taken in `SUM_SET` on the clear input or on a counter write with bit 63 clear. Every other case keeps the current state.

Top module: `cyc_counter_top`

## Requirements
- R1: Reset sets the count to zero and clears the overflow flag (bit 63), the summary bit and the interrupt. It also leaves the counter not inhibited.
- R2: While the counter is not inhibited and is not being written, the 63-bit count rises by one on every clock. The read port returns {flag, count}.
- R3: An inhibit write of 1 takes effect from the next clock, so the cycle of the write itself still counts. From then on the count holds its value.
- R4: A counter write loads bits 62:0 as the new count on the next clock. It takes priority over the increment and also works while the counter is inhibited.
- R5: When the count wraps from all ones to zero and the summary bit is clear, the flag and the summary bit are set and the interrupt pulses, all on the same clock.
- R6: A wrap while the summary bit is already set gives no interrupt and leaves the summary bit and the flag set.
- R7: On a counter write, bit 63 of the write data becomes the flag. If that bit is 0, the summary bit is also cleared. If it is 1, the summary bit keeps its value.
- R8: The interrupt is high for exactly one clock and only on the clock where the summary bit rises.
- R9: The summary clear input clears the summary bit. If a first wrap happens in the same cycle, setting wins and the interrupt fires.
- R10: After an inhibit write of 0, counting resumes from the held value one clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 64 | Counter write data: bit 63 is the flag, bits 62:0 are the count |
| inh_we | input | 1 | Inhibit bit write strobe |
| inh_wdata | input | 1 | New inhibit value (1 = freeze) |
| sum_clr | input | 1 | Clears the overflow summary bit |
| cnt_rdata | output | 64 | {overflow flag, 63-bit count} |
| inh_rdata | output | 1 | Current inhibit bit |
| sum_rdata | output | 1 | Overflow summary bit |
| pm_irq | output | 1 | One-cycle performance-monitor interrupt request |

## Verification
The counting function is driven by steady runs that show the per-cycle increment, and by inhibit writes that show the one-cycle delay before a freeze or resume takes effect. It is also driven by loads near the top of the range, which show that the wrap is caught exactly at the all-ones value. Wraps are set up with the summary bit both clear and already set, which tells a first overflow (interrupt) apart from a repeated one (silent). Loads with bit 63 set and with it clear show which writes acknowledge the summary bit. A frozen count held at all ones shows that an inhibited counter never wraps. A clear issued in the same cycle as a wrap shows that setting wins over clearing.

// File: rtl/cyccnt_pkg.sv
package cyccnt_pkg;

    // Default width of the count field; the register adds one flag bit on top.
    localparam int CNT_W_DEF = 63;

    // Inhibit control machine.
    typedef enum logic [0:0] {
        CTL_RUN  = 1'b0,
        CTL_HOLD = 1'b1
    } ctl_state_e;

    // Overflow summary machine.
    typedef enum logic [0:0] {
        SUM_IDLE = 1'b0,
        SUM_SET  = 1'b1
    } sum_state_e;

endpackage

// File: rtl/cyc_inhibit_fsm.sv
module cyc_inhibit_fsm
    import cyccnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inh_we,
    input  logic inh_wdata,
    output logic count_en,
    output logic inhibited
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: freeze and resume transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_RUN: begin
                if (inh_we && inh_wdata) begin
                    state_d = CTL_HOLD;
                end
            end
            CTL_HOLD: begin
                if (inh_we && !inh_wdata) begin
                    state_d = CTL_RUN;
                end
            end
            default: state_d = CTL_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        count_en  = 1'b0;
        inhibited = 1'b0;
        unique case (state_q)
            CTL_RUN:  count_en  = 1'b1;
            CTL_HOLD: inhibited = 1'b1;
            default: begin
                count_en  = 1'b0;
                inhibited = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             load,
    input  logic [REG_W-1:0] load_data,
    input  logic             first_ovf,
    output logic             wrap,
    output logic [REG_W-1:0] reg_value
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    // The wrap is only a real event when the increment is the chosen update.
    assign wrap = count_en && !load && (&cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_data[CNT_W-1:0];
            flag_q <= load_data[CNT_W];
        end else if (count_en) begin
            cnt_q <= cnt_q + ONE;
            if (first_ovf) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign reg_value = {flag_q, cnt_q};

endmodule

// File: rtl/cyc_ovf_tracker.sv
module cyc_ovf_tracker
    import cyccnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic sum_clr,
    input  logic load,
    input  logic load_msb,
    output logic first_ovf,
    output logic summary,
    output logic irq
);

    sum_state_e state_q;
    sum_state_e state_d;
    logic       irq_q;

    // State register plus the registered interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUM_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= first_ovf;
        end
    end

    // Next state: first overflow and acknowledge transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE: begin
                if (wrap) begin
                    state_d = SUM_SET;
                end
            end
            SUM_SET: begin
                if (sum_clr || (load && !load_msb)) begin
                    state_d = SUM_IDLE;
                end
            end
            default: state_d = SUM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        first_ovf = 1'b0;
        summary   = 1'b0;
        unique case (state_q)
            SUM_IDLE: first_ovf = wrap;
            SUM_SET:  summary   = 1'b1;
            default: begin
                first_ovf = 1'b0;
                summary   = 1'b0;
            end
        endcase
    end

    assign irq = irq_q;

endmodule

// File: rtl/cyc_counter_top.sv
module cyc_counter_top
    import cyccnt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [REG_W-1:0] cnt_wdata,
    input  logic             inh_we,
    input  logic             inh_wdata,
    input  logic             sum_clr,
    output logic [REG_W-1:0] cnt_rdata,
    output logic             inh_rdata,
    output logic             sum_rdata,
    output logic             pm_irq
);

    logic count_en;
    logic wrap;
    logic first_ovf;

    cyc_inhibit_fsm u_inhibit (
        .clk       (clk),
        .rst_n     (rst_n),
        .inh_we    (inh_we),
        .inh_wdata (inh_wdata),
        .count_en  (count_en),
        .inhibited (inh_rdata)
    );

    cyc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .load      (cnt_we),
        .load_data (cnt_wdata),
        .first_ovf (first_ovf),
        .wrap      (wrap),
        .reg_value (cnt_rdata)
    );

    cyc_ovf_tracker u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .sum_clr   (sum_clr),
        .load      (cnt_we),
        .load_msb  (cnt_wdata[CNT_W]),
        .first_ovf (first_ovf),
        .summary   (sum_rdata),
        .irq       (pm_irq)
    );

endmodule

// File: rtl/cyc_counter_chk.sv
module cyc_counter_chk #(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_we,
    input logic [REG_W-1:0] cnt_wdata,
    input logic             sum_clr,
    input logic [REG_W-1:0] cnt_rdata,
    input logic             inh_rdata,
    input logic             sum_rdata,
    input logic             pm_irq
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_v;
    logic             flag_v;
    assign cnt_v  = cnt_rdata[CNT_W-1:0];
    assign flag_v = cnt_rdata[CNT_W];

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_rdata && !cnt_we && !(&cnt_v)) |=> (cnt_v == $past(cnt_v) + ONE));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_rdata && !cnt_we) |=> $stable(cnt_v));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_v == $past(cnt_wdata[CNT_W-1:0])));

    assert_first_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_rdata && !cnt_we && (&cnt_v) && !sum_rdata)
        |=> (pm_irq && sum_rdata && flag_v && (cnt_v == '0)));

    assert_no_repeat_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_rdata && !sum_clr && !(cnt_we && !cnt_wdata[CNT_W])) |=> !pm_irq);

    assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !cnt_wdata[CNT_W]) |=> (!sum_rdata && !flag_v));

    assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_irq |-> $rose(sum_rdata));

endmodule

bind cyc_counter_top cyc_counter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .sum_clr   (sum_clr),
    .cnt_rdata (cnt_rdata),
    .inh_rdata (inh_rdata),
    .sum_rdata (sum_rdata),
    .pm_irq    (pm_irq)
);

// File: tb/cyc_counter_top_tb.sv
module cyc_counter_top_tb;

    localparam logic [63:0] MAXC = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] TOPB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        wc;
        logic [63:0] wd;
        logic        wi;
        logic        id;
        logic        cl;
        logic [63:0] er;
        logic        es;
        logic        eq;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 64'd100,   1'b0, 1'b0, 1'b0, 64'd100,     1'b0, 1'b0, "R4"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd101,     1'b0, 1'b0, "R2"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd102,     1'b0, 1'b0, "R2"},
        '{1'b0, 64'd0,     1'b1, 1'b1, 1'b0, 64'd103,     1'b0, 1'b0, "R3"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd103,     1'b0, 1'b0, "R3"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd103,     1'b0, 1'b0, "R3"},
        '{1'b1, 64'd500,   1'b0, 1'b0, 1'b0, 64'd500,     1'b0, 1'b0, "R4"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd500,     1'b0, 1'b0, "R3"},
        '{1'b0, 64'd0,     1'b1, 1'b0, 1'b0, 64'd500,     1'b0, 1'b0, "R10"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, 64'd501,     1'b0, 1'b0, "R10"},
        '{1'b1, MAXC-64'd1, 1'b0, 1'b0, 1'b0, MAXC-64'd1, 1'b0, 1'b0, "R4"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R2"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, TOPB,        1'b1, 1'b1, "R5"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, TOPB+64'd1,  1'b1, 1'b0, "R8"},
        '{1'b1, MAXC,      1'b0, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R7"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, TOPB,        1'b1, 1'b1, "R5"},
        '{1'b1, ALL1,      1'b0, 1'b0, 1'b0, ALL1,        1'b1, 1'b0, "R7"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, TOPB,        1'b1, 1'b0, "R6"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b1, TOPB+64'd1,  1'b0, 1'b0, "R9"},
        '{1'b1, ALL1,      1'b0, 1'b0, 1'b0, ALL1,        1'b0, 1'b0, "R7"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, TOPB,        1'b1, 1'b1, "R5"},
        '{1'b0, 64'd0,     1'b1, 1'b1, 1'b0, TOPB+64'd1,  1'b1, 1'b0, "R3"},
        '{1'b1, MAXC,      1'b0, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R7"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R3"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R3"},
        '{1'b0, 64'd0,     1'b1, 1'b0, 1'b0, MAXC,        1'b0, 1'b0, "R10"},
        '{1'b0, 64'd0,     1'b0, 1'b0, 1'b1, TOPB,        1'b1, 1'b1, "R9"}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_we;
    logic [63:0] cnt_wdata;
    logic        inh_we;
    logic        inh_wdata;
    logic        sum_clr;
    logic [63:0] cnt_rdata;
    logic        inh_rdata;
    logic        sum_rdata;
    logic        pm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cyc_counter_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .inh_we    (inh_we),
        .inh_wdata (inh_wdata),
        .sum_clr   (sum_clr),
        .cnt_rdata (cnt_rdata),
        .inh_rdata (inh_rdata),
        .sum_rdata (sum_rdata),
        .pm_irq    (pm_irq)
    );

    task automatic check(input string req, input logic [63:0] rd, input logic sm,
                         input logic iq, input logic ih, input logic [63:0] erd,
                         input logic esm, input logic eiq, input logic eih);
        checks++;
        if (rd !== erd || sm !== esm || iq !== eiq || ih !== eih) begin
            fails++;
            $display("FAIL %s: rd=%h sum=%b irq=%b inh=%b expected rd=%h sum=%b irq=%b inh=%b",
                     req, rd, sm, iq, ih, erd, esm, eiq, eih);
        end
    endtask

    task automatic idle_inputs();
        cnt_we    = 1'b0;
        cnt_wdata = '0;
        inh_we    = 1'b0;
        inh_wdata = 1'b0;
        sum_clr   = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        logic inh_exp;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", cnt_rdata, sum_rdata, pm_irq, inh_rdata, 64'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: free-running from reset
        check("R2", cnt_rdata, sum_rdata, pm_irq, inh_rdata, 64'd1, 1'b0, 1'b0, 1'b0);

        inh_exp = 1'b0;
        for (int i = 0; i < NV; i++) begin
            cnt_we    = VEC[i].wc;
            cnt_wdata = VEC[i].wd;
            inh_we    = VEC[i].wi;
            inh_wdata = VEC[i].id;
            sum_clr   = VEC[i].cl;
            if (VEC[i].wi) inh_exp = VEC[i].id;
            @(negedge clk);
            check(string'(VEC[i].tag), cnt_rdata, sum_rdata, pm_irq, inh_rdata,
                  VEC[i].er, VEC[i].es, VEC[i].eq, inh_exp);
        end
        idle_inputs();

        // R8: pulse gone one clock after the last wrap
        @(negedge clk);
        check("R8", cnt_rdata, sum_rdata, pm_irq, inh_rdata, TOPB + 64'd1, 1'b1, 1'b0, 1'b0);

        // R1: reset in mid-run clears everything, including inhibit
        inh_we = 1'b1; inh_wdata = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", cnt_rdata, sum_rdata, pm_irq, inh_rdata, 64'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2", cnt_rdata, sum_rdata, pm_irq, inh_rdata, 64'd2, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

endmodule